// File: doc/BRIEF.md
# Snooping write-through invalidate cache controller

This block is the cache controller for one processor in a small shared-bus multiprocessor. It keeps a direct-mapped, write-through cache in which every line is either valid or invalid. A processor read that hits a valid line is answered from the local copy. A read that misses wins the shared bus, fetches the word from memory and fills the line. Every processor write goes to memory over the bus. A write never allocates a line, and a write that hits also refreshes the local copy.

Coherence comes from watching the shared bus. Every completed transaction appears on an observe port together with the identifier of the cache that issued it. A write from another cache whose address matches a valid local line invalidates that line. Reads from other caches and the block's own echoed transactions have no effect. The bus is atomic: one transaction runs to completion before the next starts, and the processor holds its request until the block signals completion.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is invalid, and cpu_ready, bus_req and bus_cmd_valid are low. The first read of any address therefore misses.
- R2: A read of an invalid or mismatching line raises bus_req, then drives a read transaction (bus_cmd_we=0) after grant. The cycle after bus_done it pulses cpu_ready with cpu_rdata equal to the bus_rdata sampled with bus_done, and the line becomes valid.
- R3: A read that hits a valid line with a matching tag makes no bus request. Its cpu_ready pulse comes in the cycle after the request is accepted, and it returns the stored word.
- R4: Every processor write drives a bus write (bus_cmd_we=1) carrying the processor's address and data. A write to a non-resident line leaves that line invalid, so a following read of the same address misses.
- R5: A write that hits a valid line updates the stored word and leaves the line valid, so a following read hits and returns the written data.
- R6: An observed write (obs_valid=1, obs_we=1) with obs_id different from MY_ID invalidates the line at index obs_addr[IDX_W-1:0] when that line is valid and its tag equals obs_addr[ADDR_W-1:IDX_W].
- R7: An observed read, an observed write carrying obs_id equal to MY_ID, and an observed write whose tag differs from the resident line each leave the line state unchanged.
- R8: bus_cmd_valid rises only in the cycle after a cycle with bus_req and bus_gnt both high, and it is never high together with bus_req. Address and command stay stable until bus_done.
- R9: cpu_ready is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_ready |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd_valid | output | 1 | Own transaction on the bus |
| bus_cmd_we | output | 1 | Own transaction is a write |
| bus_addr | output | ADDR_W | Own transaction address |
| bus_wdata | output | DATA_W | Own write data |
| bus_rdata | input | DATA_W | Memory read data |
| bus_done | input | 1 | Own transaction completes this cycle |
| obs_valid | input | 1 | A bus transaction is observed |
| obs_we | input | 1 | Observed transaction is a write |
| obs_id | input | ID_W | Identifier of the issuing cache |
| obs_addr | input | ADDR_W | Observed address |

## Verification
The assertions check the bus handshake ordering and stability, the one-cycle ready pulse, the match between the bus command and the pending processor request, and the forwarding of fill data on every cycle. Whether a read hits or misses depends on the hidden line state left by earlier fills, writes and snoops. That, together with the data returned by hits and the invalidation rules for foreign, own-ID and mismatching observed traffic, is shown only by the bench's scenarios against its reference model of lines and memory.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_XFER = 2'd2,
    ST_RESP = 2'd3
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             sn_en,
  input  logic [IDX_W-1:0] sn_idx,
  input  logic [TAG_W-1:0] sn_tag,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];

  for (genvar i = 0; i < SETS; i++) begin : g_set
    logic fill_here;
    logic kill_here;
    logic valid_en;
    logic valid_d;

    assign fill_here = fill_en && (fill_idx == IDX_W'(i));
    assign kill_here = sn_en && (sn_idx == IDX_W'(i)) && valid_q[i] &&
                       (tag_q[i] == sn_tag);
    assign valid_en  = fill_here || kill_here;
    assign valid_d   = fill_here;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        valid_q[i] <= 1'b0;
      else if (valid_en) valid_q[i] <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (fill_here) tag_q[i] <= fill_tag;
    end
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int SETS   = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] line_q [SETS];

  for (genvar i = 0; i < SETS; i++) begin : g_line
    logic line_en;
    assign line_en = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (line_en) line_q[i] <= wr_data;
    end
  end

  assign rd_data = line_q[rd_idx];
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd_valid,
  output logic              bus_cmd_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] line_rdata,
  output logic [ADDR_W-1:0] lk_addr,
  output logic              fill_en,
  output logic              dwr_en,
  output logic [DATA_W-1:0] dwr_data
);
  wtc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              accept;
  logic              rdata_en;
  logic              finish;

  assign accept  = (state_q == ST_IDLE) && cpu_req;
  assign finish  = (state_q == ST_XFER) && bus_done;
  assign lk_addr = (state_q == ST_IDLE) ? cpu_addr : addr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cpu_req) state_d = (!cpu_we && lk_hit) ? ST_RESP : ST_ARB;
      ST_ARB:  if (bus_gnt) state_d = ST_XFER;
      ST_XFER: if (bus_done) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    fill_en  = finish && !we_q;
    dwr_en   = fill_en || (finish && we_q && lk_hit);
    dwr_data = we_q ? wdata_q : bus_rdata;
    rdata_en = (accept && !cpu_we && lk_hit) || fill_en;
    rdata_d  = fill_en ? bus_rdata : line_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
      we_q    <= cpu_we;
    end
    if (rdata_en) rdata_q <= rdata_d;
  end

  assign cpu_ready     = (state_q == ST_RESP);
  assign cpu_rdata     = rdata_q;
  assign bus_req       = (state_q == ST_ARB);
  assign bus_cmd_valid = (state_q == ST_XFER);
  assign bus_cmd_we    = we_q;
  assign bus_addr      = addr_q;
  assign bus_wdata     = wdata_q;
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int SETS   = 16,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd_valid,
  output logic              bus_cmd_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done,
  input  logic              obs_valid,
  input  logic              obs_we,
  input  logic [ID_W-1:0]   obs_id,
  input  logic [ADDR_W-1:0] obs_addr
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] lk_addr;
  logic              lk_hit;
  logic              fill_en;
  logic              dwr_en;
  logic [DATA_W-1:0] dwr_data;
  logic [DATA_W-1:0] line_rdata;
  logic              sn_en;

  assign sn_en = obs_valid && obs_we && (obs_id != ID_W'(MY_ID));

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd_we(bus_cmd_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_done(bus_done),
    .lk_hit(lk_hit), .line_rdata(line_rdata), .lk_addr(lk_addr),
    .fill_en(fill_en), .dwr_en(dwr_en), .dwr_data(dwr_data)
  );

  wtc_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_addr[IDX_W-1:0]), .lk_tag(lk_addr[ADDR_W-1:IDX_W]),
    .lk_hit(lk_hit),
    .sn_en(sn_en), .sn_idx(obs_addr[IDX_W-1:0]),
    .sn_tag(obs_addr[ADDR_W-1:IDX_W]),
    .fill_en(fill_en), .fill_idx(lk_addr[IDX_W-1:0]),
    .fill_tag(lk_addr[ADDR_W-1:IDX_W])
  );

  wtc_data_store #(.SETS(SETS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .wr_en(dwr_en), .wr_idx(lk_addr[IDX_W-1:0]),
    .wr_data(dwr_data), .rd_idx(lk_addr[IDX_W-1:0]), .rd_data(line_rdata)
  );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_cmd_valid,
  input logic              bus_cmd_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_done
);
  // R8
  cmd_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cmd_valid) |-> $past(bus_req && bus_gnt));
  // R8
  req_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !bus_cmd_valid);
  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_valid && !bus_done) |=> (bus_cmd_valid && $stable(bus_addr) && $stable(bus_cmd_we)));
  // R4
  cmd_matches_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |-> (cpu_req && bus_cmd_we == cpu_we && bus_addr == cpu_addr));
  // R2
  fill_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_valid && bus_done && !bus_cmd_we) |=> (cpu_ready && cpu_rdata == $past(bus_rdata)));
  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
endmodule

bind wt_snoop_cache wtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
  .bus_cmd_we(bus_cmd_we), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .bus_done(bus_done)
);

// File: tb/tb_wt_snoop_cache.sv
`timescale 1ns/1ps
module tb_wt_snoop_cache;
  localparam int SETS = 16, ADDR_W = 16, DATA_W = 32, ID_W = 2, MY_ID = 0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DATA_W-1:0] cpu_rdata;
  logic bus_req, bus_gnt = 0, bus_cmd_valid, bus_cmd_we, bus_done = 0;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata = '0;
  logic obs_valid = 0, obs_we = 0;
  logic [ID_W-1:0] obs_id = '0;
  logic [ADDR_W-1:0] obs_addr = '0;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  wt_snoop_cache #(.SETS(SETS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .ID_W(ID_W), .MY_ID(MY_ID)) dut (.*);

  // Reference state: memory (8-bit address space used) and line model
  logic [DATA_W-1:0] mem [256];
  logic              m_v [SETS];
  logic [3:0]        m_t [SETS];
  logic [DATA_W-1:0] m_d [SETS];

  function automatic logic exp_hit(input logic [7:0] a);
    return m_v[a[3:0]] && (m_t[a[3:0]] == a[7:4]);
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One processor operation with a bus responder; returns read data and bus use
  task automatic cpu_op(input logic we, input logic [7:0] a, input logic [DATA_W-1:0] wd,
                        output logic [DATA_W-1:0] rd, output logic used_bus);
    bit granted = 0, sent = 0, early = 0, badcmd = 0, seen_ready = 0;
    int gdly = $urandom_range(0, 3), ddly = $urandom_range(0, 3);
    used_bus = 0; rd = '0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = {8'h00, a}; cpu_wdata = wd;
    for (int c = 0; c < 60 && !seen_ready; c++) begin
      @(negedge clk);
      bus_gnt = 0; bus_done = 0;
      if (cpu_ready) begin
        rd = cpu_rdata; seen_ready = 1;
        cpu_req = 0;
      end else begin
        if (bus_cmd_valid && !granted) early = 1;
        if (bus_req && !granted) begin
          used_bus = 1;
          if (gdly == 0) begin bus_gnt = 1; granted = 1; end else gdly--;
        end else if (bus_cmd_valid && !sent) begin
          if (bus_cmd_we != we || bus_addr[7:0] != a || (we && bus_wdata != wd)) badcmd = 1;
          if (ddly == 0) begin
            bus_done = 1; sent = 1;
            bus_rdata = mem[a];
            if (we) mem[a] = wd;
          end else ddly--;
        end
      end
    end
    chk(seen_ready, "R9", "ready seen", {31'd0, seen_ready}, 1);
    if (used_bus) begin
      chk(!early, "R8", "command before grant", {31'd0, early}, 0);
      chk(!badcmd, "R4", "bus command fields", {31'd0, badcmd}, 0);
    end
    @(negedge clk);
    chk(!cpu_ready, "R9", "ready single pulse", {31'd0, cpu_ready}, 0);
  endtask

  task automatic snoop(input logic we, input logic [ID_W-1:0] id, input logic [7:0] a,
                       input logic [DATA_W-1:0] d);
    @(negedge clk);
    obs_valid = 1; obs_we = we; obs_id = id; obs_addr = {8'h00, a};
    if (we && id != ID_W'(MY_ID)) begin
      mem[a] = d;
      if (exp_hit(a)) m_v[a[3:0]] = 0;
    end
    @(negedge clk);
    obs_valid = 0;
  endtask

  // Read with model update and checks
  task automatic do_read(input logic [7:0] a, input string rq);
    logic [DATA_W-1:0] rd; logic ub; logic h;
    h = exp_hit(a);
    cpu_op(0, a, '0, rd, ub);
    chk(ub == !h, rq, h ? "hit made no bus read" : "miss used bus", {31'd0, ub}, {31'd0, !h});
    chk(rd == mem[a], rq, "read data", rd, mem[a]);
    m_v[a[3:0]] = 1; m_t[a[3:0]] = a[7:4]; m_d[a[3:0]] = mem[a];
  endtask

  task automatic do_write(input logic [7:0] a, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] rd; logic ub;
    cpu_op(1, a, d, rd, ub);
    chk(ub, "R4", "write used bus", {31'd0, ub}, 1);
    if (exp_hit(a)) m_d[a[3:0]] = d;
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h0000_5EED);
    for (int i = 0; i < 256; i++) mem[i] = (32'(i) * 32'h0101_0107) ^ 32'hA5C3_0000;
    for (int i = 0; i < SETS; i++) begin m_v[i] = 0; m_t[i] = 0; m_d[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!cpu_ready && !bus_req && !bus_cmd_valid, "R1", "reset outputs",
        {29'd0, cpu_ready, bus_req, bus_cmd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: first read misses; R2 fill
    do_read(8'h05, "R1");
    // R3: read hit
    do_read(8'h05, "R3");
    // R5: write hit updates copy
    do_write(8'h05, 32'hDEAD_BEEF);
    do_read(8'h05, "R5");
    // R4: write miss does not allocate
    do_write(8'h17, 32'h1234_5678);
    do_read(8'h17, "R4");
    // R6: foreign write invalidates
    snoop(1, 2'd1, 8'h05, 32'hCAFE_0001);
    do_read(8'h05, "R6");
    // R7: own-ID write, foreign read, foreign write with other tag
    snoop(1, 2'(MY_ID), 8'h05, 32'h0);
    do_read(8'h05, "R7");
    snoop(0, 2'd2, 8'h05, 32'h0);
    do_read(8'h05, "R7");
    snoop(1, 2'd3, 8'h15, 32'hBEEF_0015);
    do_read(8'h05, "R7");
    do_read(8'h15, "R2");
    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      int k;
      a = {2'b00, 6'($urandom_range(0, 63))};
      k = $urandom_range(0, 9);
      if (k < 4)      do_read(a, "R2");
      else if (k < 6) do_write(a, $urandom);
      else if (k < 8) snoop(1, 2'($urandom_range(1, 3)), a, $urandom);
      else if (k < 9) snoop(0, 2'($urandom_range(0, 3)), a, 32'h0);
      else            snoop(1, 2'(MY_ID), a, 32'h0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule